// File: doc/BRIEF.md
# Multi-Level Trigger and Store Sequencer

This block sits behind a bus-state classifier in a logic-analyzer front end. On every clock it receives a vector of qualification terms, such as address phase, data phase, retry, configuration phase and idle. It registers that vector once. Two outputs follow from it: `store` marks whether the current state should go to capture memory, and `trig` marks the clock on which the trigger fires. Up to four sequence levels are programmed through static configuration inputs. For each level the configuration sets:

- which terms cause a store;
- which of those terms are time-gated;
- the find term and how many times it must occur;
- the level to go to on a find;
- an else term and the level to go to on it;
- whether entering the level restarts the timer.

One clock-counting timer provides time gating. A gated term qualifies in one of two ways. In the first, it counts only while the timer is below its limit, which keeps the opening transfers of a long burst. In the second, it counts only once the limit has been reached, which keeps the tail of an aborted cycle without keeping ordinary wait states. Levels can branch to any level, so a sequence can return to an earlier level on the next address phase or on idle. Leaving the designated trigger level produces a one-clock trigger pulse.

Top module: `trig_seq_ctl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `lvl` is 0, `trig` is 0 and `store` is 0.
- R2: `store` is high in the clock after a term vector is presented exactly when some term set in that vector is also set in the current level's store mask. A term counts without condition if its gate bit is clear, and under the timer condition of R7/R8 if its gate bit is set.
- R3: When the current level's find term is present, that level's occurrence count increments. On the occurrence that reaches the programmed count, `lvl` moves to the level's find target one clock later. A programmed count of 0 behaves as 1. The count clears on every level entry.
- R4: When no find term is present and the level's else term is present, `lvl` moves to the else target. A find term always takes precedence over the else term.
- R5: `trig` is high for exactly one clock, in the clock where `lvl` first shows a level other than the programmed trigger level after a branch out of it. A branch from the trigger level back to itself gives no pulse.
- R6: On any branch, including one back to the same level, the timer restarts from 0 if the target level's start bit is set. Otherwise the timer advances by one per clock and saturates at its maximum value instead of wrapping.
- R7: With the level's gate mode bit at 0, a gated term qualifies only while the timer value is below the limit.
- R8: With the level's gate mode bit at 1, a gated term qualifies only while the timer value is at or above the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_in | input | NTERM | Per-clock classifier term vector |
| cfg_store | input | NLVL*NTERM | Store mask per level; level k occupies bits k*NTERM upward |
| cfg_gate | input | NLVL*NTERM | Per-level mask of store terms that are timer-gated |
| cfg_above | input | NLVL | Gate mode per level: 0 = below limit, 1 = at or above limit |
| cfg_find | input | NLVL*NTERM | Find term mask per level |
| cfg_count | input | NLVL*CNTW | Occurrences needed per level (0 treated as 1) |
| cfg_find_to | input | NLVL*LW | Target level on find |
| cfg_else | input | NLVL*NTERM | Else term mask per level (all zero disables) |
| cfg_else_to | input | NLVL*LW | Target level on else |
| cfg_tstart | input | NLVL | Restart the timer when this level is entered |
| cfg_trig_lvl | input | LW | Level whose exit produces the trigger pulse |
| cfg_limit | input | TMRW | Timer limit in clocks |
| store | output | 1 | Store strobe for the current registered state |
| trig | output | 1 | One-clock trigger pulse |
| lvl | output | LW | Current sequence level |

## Verification
The bench targets these corner cases:

- **Count of three (R3).** The level must hold for two hits and move on the third. A counter that is not cleared on entry would instead advance early on a later visit.
- **Find and else in the same clock (R4).** Find must win. A design with the priority reversed would take the else target.
- **Self-branch on the trigger level (R5).** No pulse may appear. A design that compares against the level instead of the exit would pulse here.
- **Window of three clocks (R7).** The store must drop after exactly three clocks. A timer compare that is off by one shifts that edge by a cycle.
- **Held term at the maximum limit (R6, R8).** The bench holds a gated term for longer than the timer range. A wrapping timer would make the store fall back to 0 after 1024 clocks.

Random configurations and term streams are run against a bench reference model on top of these directed cases.

// File: rtl/trig_seq_ctl.sv
module trig_seq_ctl #(
  parameter int NTERM = 8,
  parameter int NLVL  = 4,
  parameter int CNTW  = 8,
  parameter int TMRW  = 10,
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTERM-1:0]     term_in,
  input  logic [NLVL*NTERM-1:0] cfg_store,
  input  logic [NLVL*NTERM-1:0] cfg_gate,
  input  logic [NLVL-1:0]      cfg_above,
  input  logic [NLVL*NTERM-1:0] cfg_find,
  input  logic [NLVL*CNTW-1:0] cfg_count,
  input  logic [NLVL*LW-1:0]   cfg_find_to,
  input  logic [NLVL*NTERM-1:0] cfg_else,
  input  logic [NLVL*LW-1:0]   cfg_else_to,
  input  logic [NLVL-1:0]      cfg_tstart,
  input  logic [LW-1:0]        cfg_trig_lvl,
  input  logic [TMRW-1:0]      cfg_limit,
  output logic                 store,
  output logic                 trig,
  output logic [LW-1:0]        lvl
);
  logic [NTERM-1:0] term_q;
  logic [LW-1:0]    lvl_q;
  logic [CNTW-1:0]  occ;
  logic [TMRW-1:0]  tmr;
  logic             trig_q;

  logic [NTERM-1:0] smask, gmask, fmask, emask;
  logic [CNTW-1:0]  need;
  logic [LW-1:0]    fto, eto, nxt;
  logic             gate_ok, find_hit, else_hit, done, take, restart;

  assign smask = cfg_store[lvl_q*NTERM +: NTERM];
  assign gmask = cfg_gate[lvl_q*NTERM +: NTERM];
  assign fmask = cfg_find[lvl_q*NTERM +: NTERM];
  assign emask = cfg_else[lvl_q*NTERM +: NTERM];
  assign need  = (cfg_count[lvl_q*CNTW +: CNTW] == '0) ? CNTW'(1) : cfg_count[lvl_q*CNTW +: CNTW];
  assign fto   = cfg_find_to[lvl_q*LW +: LW];
  assign eto   = cfg_else_to[lvl_q*LW +: LW];

  assign gate_ok  = cfg_above[lvl_q] ? (tmr >= cfg_limit) : (tmr < cfg_limit);
  assign store    = |(term_q & smask & (~gmask | {NTERM{gate_ok}}));
  assign find_hit = |(term_q & fmask);
  assign else_hit = !find_hit && |(term_q & emask);
  assign done     = find_hit && ({1'b0, occ} + 1'b1 >= {1'b0, need});
  assign take     = done || else_hit;
  assign nxt      = done ? fto : eto;
  assign restart  = take && cfg_tstart[nxt];

  assign trig = trig_q;
  assign lvl  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      lvl_q  <= '0;
      occ    <= '0;
      tmr    <= '0;
      trig_q <= 1'b0;
    end else begin
      term_q <= term_in;
      trig_q <= take && (lvl_q == cfg_trig_lvl) && (nxt != lvl_q);
      if (take) begin
        lvl_q <= nxt;
        occ   <= '0;
      end else if (find_hit) begin
        occ <= occ + 1'b1;
      end
      if (restart)         tmr <= '0;
      else if (tmr != '1)  tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int NTERM = 8,
  parameter int LW    = 2,
  parameter int TMRW  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTERM-1:0] term_q,
  input logic [NTERM-1:0] smask,
  input logic [NTERM-1:0] fmask,
  input logic [NTERM-1:0] emask,
  input logic [LW-1:0]    lvl,
  input logic [LW-1:0]    cfg_trig_lvl,
  input logic [TMRW-1:0]  tmr,
  input logic             restart,
  input logic             store,
  input logic             trig
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (lvl == '0 && !trig));

  p_store_needs_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> |(term_q & smask));

  p_hold_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(term_q & fmask)) && !(|(term_q & emask)) |=> $stable(lvl));

  p_trig_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(lvl) == $past(cfg_trig_lvl) && lvl != $past(lvl)));

  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_tmr_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == '1 && !restart) |=> tmr == '1);
endmodule

bind trig_seq_ctl trig_seq_chk #(.NTERM(NTERM), .LW(LW), .TMRW(TMRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .term_q(term_q), .smask(smask), .fmask(fmask),
  .emask(emask), .lvl(lvl_q), .cfg_trig_lvl(cfg_trig_lvl), .tmr(tmr),
  .restart(restart), .store(store), .trig(trig)
);

// File: tb/sim_trig_seq_ctl.sv
module sim_trig_seq_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  term_in = '0;
  logic [31:0] c_store = '0, c_gate = '0, c_find = '0, c_else = '0, c_count = '0;
  logic [3:0]  c_above = '0, c_start = '0;
  logic [7:0]  c_fto = '0, c_eto = '0;
  logic [1:0]  c_trig = '0;
  logic [9:0]  c_lim = '0;
  logic store, trig;
  logic [1:0] lvl;

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic [7:0] m_tq;
  logic [1:0] m_lvl;
  int         m_occ, m_tmr;
  logic       m_trig;

  always #5 clk = ~clk;

  trig_seq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .term_in(term_in), .cfg_store(c_store),
    .cfg_gate(c_gate), .cfg_above(c_above), .cfg_find(c_find), .cfg_count(c_count),
    .cfg_find_to(c_fto), .cfg_else(c_else), .cfg_else_to(c_eto), .cfg_tstart(c_start),
    .cfg_trig_lvl(c_trig), .cfg_limit(c_lim), .store(store), .trig(trig), .lvl(lvl)
  );

  function automatic logic exp_store();
    logic r = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (m_tq[i] && c_store[m_lvl*8+i]) begin
        if (!c_gate[m_lvl*8+i]) r = 1'b1;
        else if (c_above[m_lvl] ? (m_tmr >= int'(c_lim)) : (m_tmr < int'(c_lim))) r = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic model_reset();
    m_tq = '0; m_lvl = '0; m_occ = 0; m_tmr = 0; m_trig = 1'b0;
  endtask

  task automatic model_tick(input logic [7:0] t);
    logic hit, alt, adv;
    int need;
    logic [1:0] tgt;
    hit  = |(m_tq & c_find[m_lvl*8 +: 8]);
    alt  = !hit && |(m_tq & c_else[m_lvl*8 +: 8]);
    need = int'(c_count[m_lvl*8 +: 8]);
    if (need == 0) need = 1;
    adv  = hit && (m_occ + 1 == need);
    tgt  = adv ? c_fto[m_lvl*2 +: 2] : c_eto[m_lvl*2 +: 2];
    m_trig = (adv || alt) && (m_lvl == c_trig) && (tgt != m_lvl);
    if ((adv || alt) && c_start[tgt]) m_tmr = 0;
    else if (m_tmr < 1023) m_tmr = m_tmr + 1;
    if (adv || alt) begin m_lvl = tgt; m_occ = 0; end
    else if (hit) m_occ = m_occ + 1;
    m_tq = t;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    string st;
    st = (|(m_tq & c_gate[m_lvl*8 +: 8] & c_store[m_lvl*8 +: 8])) ?
         (c_above[m_lvl] ? "R8 gated store" : "R7 gated store") : "R2 store";
    check(st, int'(store), int'(exp_store()));
    check("R3/R4 level", int'(lvl), int'(m_lvl));
    check("R5 trigger", int'(trig), int'(m_trig));
  endtask

  task automatic step(input logic [7:0] t);
    term_in = t;
    @(posedge clk); #1;
    cyc++;
    model_tick(t);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; term_in = '0;
    model_reset();
    @(negedge clk);
    check("R1 reset level", int'(lvl), 0);
    check("R1 reset trigger", int'(trig), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_tick(8'h00);
    check("R1 level after release", int'(lvl), 0);
    check("R1 store after release", int'(store), 0);
  endtask

  task automatic cfg_clear();
    c_store = '0; c_gate = '0; c_find = '0; c_else = '0; c_count = '0;
    c_above = '0; c_start = '0; c_fto = '0; c_eto = '0; c_trig = '0; c_lim = '0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R3: count of three on level 0, counter cleared on re-entry
    cfg_clear();
    c_find[7:0] = 8'h01; c_count[7:0] = 8'd3; c_fto[1:0] = 2'd1;
    c_else[15:8] = 8'h80; c_eto[3:2] = 2'd0; c_find[15:8] = 8'h00;
    c_store[7:0] = 8'h03;
    do_reset();
    step(8'h01); step(8'h02); step(8'h01); step(8'h00); step(8'h01); step(8'h00);
    step(8'h00);
    check("R3 advanced after third hit", int'(lvl), 1);
    step(8'h80); step(8'h01); step(8'h01); step(8'h00); step(8'h00);
    check("R3 count cleared on entry", int'(lvl), 0);

    // R4: find beats else in the same clock; R5: self-branch gives no pulse
    cfg_clear();
    c_trig = 2'd1;
    c_find[7:0] = 8'h01; c_fto[1:0] = 2'd1;
    c_find[15:8] = 8'h02; c_fto[3:2] = 2'd2;
    c_else[15:8] = 8'h06; c_eto[3:2] = 2'd1;
    c_else[23:16] = 8'h10; c_eto[5:4] = 2'd1;
    do_reset();
    step(8'h01); step(8'h00);
    step(8'h04); step(8'h00);
    check("R5 no pulse on self-branch", int'(trig), 0);
    step(8'h06); step(8'h00);
    check("R4 find wins over else", int'(lvl), 2);
    step(8'h10); step(8'h00);
    step(8'h02); step(8'h00);

    // R7: three-clock window after entry; R6 restart on entry
    cfg_clear();
    c_find[7:0] = 8'h01; c_fto[1:0] = 2'd1; c_start[1] = 1'b1;
    c_store[15:8] = 8'h06; c_gate[15:8] = 8'h04; c_lim = 10'd3;
    c_find[15:8] = 8'h80; c_fto[3:2] = 2'd0;
    do_reset();
    for (int k = 0; k < 30; k++) step(8'h04);
    step(8'h01);
    for (int k = 0; k < 6; k++) step(8'h04);
    check("R7 window closed", int'(store), 0);
    step(8'h80); step(8'h01);
    for (int k = 0; k < 3; k++) step(8'h04);

    // R8 and R6: limit at timer maximum, held term must stay stored
    cfg_clear();
    c_above[0] = 1'b1; c_store[7:0] = 8'h04; c_gate[7:0] = 8'h04; c_lim = 10'h3FF;
    do_reset();
    for (int k = 0; k < 1100; k++) step(8'h04);
    check("R6 timer saturates, R8 still open", int'(store), 1);

    // random configurations
    for (int e = 0; e < 40; e++) begin
      c_store = $urandom; c_gate = $urandom; c_find = $urandom & $urandom;
      c_else = $urandom & $urandom & $urandom;
      c_count = $urandom & 32'h03030303;
      c_above = 4'($urandom); c_start = 4'($urandom);
      c_fto = 8'($urandom); c_eto = 8'($urandom); c_trig = 2'($urandom);
      c_lim = 10'($urandom_range(0, 12));
      do_reset();
      for (int k = 0; k < 400; k++) step(8'($urandom & $urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule